// File: doc/BRIEF.md
# Byte-Lane Load/Store Alignment Unit

This unit sits between a word-wide data memory and the register file write-back path. It lets the core do word and byte accesses at any byte address while the memory port only ever deals in whole words. On a load it takes the word that memory returned for the addressed word. It picks the byte named by the low address bits and widens it to a full register value, with either sign extension or zero extension. On a store it spreads the source register's data across the byte lanes and raises per-lane write enables. A single-byte store therefore writes one lane in one access and never needs a load first.

The request (operation, low address bits, memory read word and register source data) is presented in one cycle. The results are registered and appear on the outputs after the next rising clock edge. A word access whose low address bits are not zero is not carried out: it raises a misalignment flag instead.

Top module: `lsa_unit`

## Requirements
- R1: While reset is active and in the first cycle after it is released, every output is zero.
- R2: An accepted word load (op code 0) with low address bits 00 gives wb_valid_o=1 and wb_data_o equal to mem_rdata_i, one clock edge after the request.
- R3: A signed byte load (op code 1) selects byte lane k = addr_lo_i, which is bits 8k+7..8k (lane 0 = bits 7..0, lane 3 = bits 31..24). It returns that byte in bits 7..0 and copies its bit 7 into bits 31..8, with wb_valid_o=1.
- R4: An unsigned byte load (op code 2) selects the lane in the same way as R3 and returns it with bits 31..8 forced to zero, with wb_valid_o=1.
- R5: An accepted word store (op code 4) with low address bits 00 drives wr_be_o=1111 and wr_data_o equal to rt_data_i.
- R6: A byte store (op code 5) drives wr_data_o with rt_data_i bits 7..0 copied into all four lanes. wr_be_o has exactly one bit set, bit addr_lo_i.
- R7: A word load or word store with addr_lo_i not 00 sets misalign_o=1 and drives wr_be_o=0000 and wb_valid_o=0.
- R8: With req_valid_i low, or with an op code outside {0,1,2,4,5}, the next outputs are wb_valid_o=0, wr_be_o=0000, misalign_o=0 and zero data.
- R9: A load never drives any write enable and leaves wr_data_o zero. A store never raises wb_valid_o and leaves wb_data_o zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 3 | Operation: 0 word load, 1 signed byte load, 2 unsigned byte load, 4 word store, 5 byte store |
| addr_lo_i | input | 2 | Low byte-offset bits of the effective address |
| mem_rdata_i | input | 32 | Word read from memory at the word address |
| rt_data_i | input | 32 | Store source register value |
| wb_valid_o | output | 1 | Load result valid for write-back |
| wb_data_o | output | 32 | Extended load result |
| wr_be_o | output | 4 | Per-lane memory write enables |
| wr_data_o | output | 32 | Lane-placed store data |
| misalign_o | output | 1 | Word access at a non-zero byte offset |

## Verification
Byte loads are tried on memory words with distinct values in each lane, at all four offsets. This shows whether the right lane was taken rather than a neighbour. Words with bit 7 of the chosen byte set and clear separate sign extension from zero extension. Byte stores at each offset, with an rt value whose low byte differs from its other bytes, show both the enable lane and the source of the replicated byte. Random traffic mixes in misaligned word accesses, invalid op codes and idle cycles to catch stray enables or valid flags.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
    typedef enum logic [2:0] {
        OP_LW  = 3'd0,
        OP_LB  = 3'd1,
        OP_LBU = 3'd2,
        OP_SW  = 3'd4,
        OP_SB  = 3'd5
    } lsa_op_e;
endpackage

// File: rtl/lsa_load_lane.sv
module lsa_load_lane #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES = DATA_W / BYTE_W,
    localparam int OFS_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic              sign_ext_i,
    output logic [DATA_W-1:0] result_o
);
    logic [BYTE_W-1:0] lane_bytes [LANES];
    logic [BYTE_W-1:0] picked;
    logic              fill;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bytes[g] = word_i[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        picked   = lane_bytes[ofs_i];
        fill     = sign_ext_i & picked[BYTE_W-1];
        result_o = {{(DATA_W-BYTE_W){fill}}, picked};
    end
endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES = DATA_W / BYTE_W,
    localparam int OFS_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic              is_byte_i,
    output logic [DATA_W-1:0] wdata_o,
    output logic [LANES-1:0]  be_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wdata_o[g*BYTE_W +: BYTE_W] = is_byte_i ? src_i[BYTE_W-1:0]
                                                       : src_i[g*BYTE_W +: BYTE_W];
        assign be_o[g] = !is_byte_i || (ofs_i == OFS_W'(g));
    end
endmodule

// File: rtl/lsa_unit.sv
module lsa_unit #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES = DATA_W / BYTE_W,
    localparam int OFS_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [2:0]        req_op_i,
    input  logic [OFS_W-1:0]  addr_lo_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic [DATA_W-1:0] rt_data_i,
    output logic              wb_valid_o,
    output logic [DATA_W-1:0] wb_data_o,
    output logic [LANES-1:0]  wr_be_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              misalign_o
);
    import lsa_pkg::*;

    typedef struct packed {
        logic              wb_valid;
        logic [DATA_W-1:0] wb_data;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
        logic              misalign;
    } out_t;

    out_t              st_d, st_q;
    logic [DATA_W-1:0] ld_ext;
    logic [DATA_W-1:0] st_lanes;
    logic [LANES-1:0]  st_be;
    logic              aligned;

    lsa_load_lane #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_load (
        .word_i     (mem_rdata_i),
        .ofs_i      (addr_lo_i),
        .sign_ext_i (req_op_i == OP_LB),
        .result_o   (ld_ext)
    );

    lsa_store_lane #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_store (
        .src_i     (rt_data_i),
        .ofs_i     (addr_lo_i),
        .is_byte_i (req_op_i == OP_SB),
        .wdata_o   (st_lanes),
        .be_o      (st_be)
    );

    always_comb begin
        st_d    = '0;
        aligned = (addr_lo_i == '0);
        if (req_valid_i) begin
            case (req_op_i)
                OP_LW: begin
                    if (aligned) begin
                        st_d.wb_valid = 1'b1;
                        st_d.wb_data  = mem_rdata_i;
                    end else begin
                        st_d.misalign = 1'b1;
                    end
                end
                OP_LB, OP_LBU: begin
                    st_d.wb_valid = 1'b1;
                    st_d.wb_data  = ld_ext;
                end
                OP_SW: begin
                    if (aligned) begin
                        st_d.be    = st_be;
                        st_d.wdata = st_lanes;
                    end else begin
                        st_d.misalign = 1'b1;
                    end
                end
                OP_SB: begin
                    st_d.be    = st_be;
                    st_d.wdata = st_lanes;
                end
                default: st_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wb_valid_o = st_q.wb_valid;
    assign wb_data_o  = st_q.wb_data;
    assign wr_be_o    = st_q.be;
    assign wr_data_o  = st_q.wdata;
    assign misalign_o = st_q.misalign;

    AST_LW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_op_i == OP_LW && addr_lo_i == '0)
        |=> (wb_valid_o && wb_data_o == $past(mem_rdata_i))); // R2
    AST_LBU_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_op_i == OP_LBU)
        |=> (wb_data_o[DATA_W-1:BYTE_W] == '0)); // R4
    AST_SW_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_op_i == OP_SW && addr_lo_i == '0)
        |=> (wr_be_o == '1 && wr_data_o == $past(rt_data_i))); // R5
    AST_SB_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_op_i == OP_SB) |=> ($countones(wr_be_o) == 1)); // R6
    AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |-> (wr_be_o == '0 && !wb_valid_o)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (wr_be_o == '0 && !wb_valid_o && !misalign_o)); // R8
    AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> (wr_be_o == '0)); // R9
endmodule

// File: tb/lsa_unit_test.sv
module lsa_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [2:0]  req_op_i = 3'd0;
    logic [1:0]  addr_lo_i = 2'd0;
    logic [31:0] mem_rdata_i = 32'd0;
    logic [31:0] rt_data_i = 32'd0;
    logic        wb_valid_o;
    logic [31:0] wb_data_o;
    logic [3:0]  wr_be_o;
    logic [31:0] wr_data_o;
    logic        misalign_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    lsa_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
        .addr_lo_i(addr_lo_i), .mem_rdata_i(mem_rdata_i), .rt_data_i(rt_data_i),
        .wb_valid_o(wb_valid_o), .wb_data_o(wb_data_o), .wr_be_o(wr_be_o),
        .wr_data_o(wr_data_o), .misalign_o(misalign_o)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] pick_byte(logic [31:0] w, logic [1:0] o, bit sgn);
        logic [7:0] b = 8'(w >> (o * 8));
        return sgn ? {{24{b[7]}}, b} : {24'd0, b};
    endfunction

    task automatic run_op(bit v, logic [2:0] op, logic [1:0] a, logic [31:0] rd, logic [31:0] rt);
        logic        e_wbv = 0, e_mis = 0;
        logic [31:0] e_wbd = 0, e_wd = 0;
        logic [3:0]  e_be = 0;
        string       tag = "R8";
        @(negedge clk);
        req_valid_i = v; req_op_i = op; addr_lo_i = a; mem_rdata_i = rd; rt_data_i = rt;
        if (v) begin
            case (op)
                3'd0: if (a == 0) begin e_wbv = 1; e_wbd = rd; tag = "R2"; end
                      else begin e_mis = 1; tag = "R7"; end
                3'd1: begin e_wbv = 1; e_wbd = pick_byte(rd, a, 1); tag = "R3"; end
                3'd2: begin e_wbv = 1; e_wbd = pick_byte(rd, a, 0); tag = "R4"; end
                3'd4: if (a == 0) begin e_be = 4'hF; e_wd = rt; tag = "R5"; end
                      else begin e_mis = 1; tag = "R7"; end
                3'd5: begin e_be = 4'b0001 << a; e_wd = {4{rt[7:0]}}; tag = "R6"; end
                default: tag = "R8";
            endcase
        end
        @(negedge clk);
        check({tag, " wb_valid"}, 32'(wb_valid_o), 32'(e_wbv));
        check({tag, " wb_data"}, wb_data_o, e_wbd);
        check({tag, " wr_be"}, 32'(wr_be_o), 32'(e_be));
        check({tag, " wr_data"}, wr_data_o, e_wd);
        check({tag, " misalign"}, 32'(misalign_o), 32'(e_mis));
        if (v && op inside {3'd0, 3'd1, 3'd2}) check("R9 load no be", 32'(wr_be_o), 32'd0);
        if (v && op inside {3'd4, 3'd5}) check("R9 store no wb", 32'(wb_valid_o), 32'd0);
        req_valid_i = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 reset wb_valid", 32'(wb_valid_o), 32'd0);
        check("R1 reset wr_be", 32'(wr_be_o), 32'd0);
        check("R1 reset misalign", 32'(misalign_o), 32'd0);
        rst_n = 1;
        @(negedge clk);
        check("R1 post-reset wb_data", wb_data_o, 32'd0);
        check("R1 post-reset wr_data", wr_data_o, 32'd0);
        for (int k = 0; k < 4; k++) begin
            run_op(1, 3'd1, 2'(k), 32'h80FF7F01, 32'h0);      // R3 mixed sign lanes
            run_op(1, 3'd2, 2'(k), 32'h80FF7F01, 32'h0);      // R4
            run_op(1, 3'd5, 2'(k), 32'h0, 32'hAABBCC5A);      // R6
            run_op(1, 3'd0, 2'(k), 32'h11223344, 32'h0);      // R2 / R7
            run_op(1, 3'd4, 2'(k), 32'h0, 32'hDEADBEEF);      // R5 / R7
        end
        run_op(0, 3'd4, 2'd0, 32'h1, 32'hFFFFFFFF);           // R8 idle
        run_op(1, 3'd3, 2'd1, 32'h1, 32'hFFFFFFFF);           // R8 bad op
        run_op(1, 3'd7, 2'd0, 32'h1, 32'hFFFFFFFF);           // R8 bad op
        for (int i = 0; i < 400; i++) begin
            run_op(($urandom % 8) != 0, 3'($urandom), 2'($urandom), $urandom, $urandom);
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule